// File: doc/BRIEF.md
# Memory-Table Interrupt Scan Dispatcher

This block sits on the receiving side of a memory-reported interrupt scheme. Units that raise an interrupt do not set a register bit. They write a marker byte into a table in local memory. When the interrupt input fires and the table region is valid, the dispatcher walks the units in a fixed order. It reads each unit's marker byte from the source table. For each marked unit, it reads the event byte from that unit's 16-byte slot in the status table. Each nonzero byte it consumes is cleared back to zero. Each recognised event then produces a one-cycle pulse on that unit's dispatch output.

The source table starts at byte offset 0x400 and holds one byte per source index. The status table starts at offset 0. A unit's slot starts at its source index times 16. Engine units have source indices 0 to NUM_ENG-1 by default. The primary controller and the media controller have their own indices (defaults 25 and 26). A well-formed marker is 0xFF. Any other nonzero value is still treated as received, but it is also reported on an error port together with its address.

Top module: `mirq_scan`

## Requirements
- R1: After reset, no memory request is made and every dispatch and error output is low.
- R2: A scan visits the engine units in ascending order, then the primary controller, then the media controller. Dispatch pulses therefore appear in that order, and at most one target pulses in any cycle.
- R3: A unit is received when its source byte at 0x400 + index is nonzero. The dispatcher writes 0x00 to that byte and then reads the status byte at index*16 + bit. The bit is ENG_BIT (default 0) for engines and CTL_BIT (default 0) for controllers.
- R4: A nonzero status byte is cleared to 0x00 and yields one dispatch pulse for that unit. A zero status byte yields no pulse. A unit whose source byte is zero has its status bytes left untouched.
- R5: A source or status byte that is nonzero and not 0xFF is still received. It also produces a one-cycle err_vld pulse carrying the byte address on err_addr and the byte value on err_val.
- R6: The media controller is visited only while has_media is 1. Otherwise its source byte is neither read nor cleared.
- R7: An interrupt that arrives while region_ok is low is ignored, and no memory access follows it.
- R8: A memory request is accepted only in a cycle with mem_gnt high. A read returns data on mem_rdata in the next cycle. Each dispatch pulse lasts exactly one cycle and comes in the cycle right after the accepted clearing write of its status byte.
- R9: One or more interrupts that arrive during a scan cause exactly one further scan, and that scan starts once the current one finishes.
- R10: Within a slot, only the selected bit's byte is tested. The other bytes of the slot keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq | input | 1 | Interrupt event, sampled each cycle |
| region_ok | input | 1 | Table region is set up; when low, interrupts are ignored |
| has_media | input | 1 | Media controller target exists |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 8 | Write data (always clears) |
| mem_rdata | input | 8 | Read data, valid the cycle after an accepted read |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| eng_disp | output | NUM_ENG | Per-engine dispatch pulses |
| pctl_disp | output | 1 | Primary controller dispatch pulse |
| mctl_disp | output | 1 | Media controller dispatch pulse |
| err_vld | output | 1 | Malformed byte seen |
| err_addr | output | ADDR_W | Address of the malformed byte |
| err_val | output | 8 | Value of the malformed byte |

## Verification
The bench runs a table of mark patterns. These include all units marked, with and without the media target, and alternating units. One pattern marks units whose status byte is zero, which separates the source test from the status test. Another sets status bytes with no source marks, which shows that slots are only read behind a marker. A sentinel byte in each slot shows that neighbours are untouched. Directed cases cover non-0xFF markers in both tables and a stalling grant, which tells pulse timing apart from write acceptance. They also cover an invalid region and a second interrupt that arrives after a unit was already passed, which only a pending rescan can pick up.

// File: rtl/mirq_pkg.sv
package mirq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_WT,
        ST_CLR,
        ST_DISP,
        ST_NEXT
    } scan_st_e;

    localparam logic [7:0] MARK_OK = 8'hFF;
    localparam int unsigned SLOT_BYTES = 16;

    // Maps a visit position (engines, then primary, then media) to its source index.
    function automatic int unsigned unit_to_idx(input int unsigned u, input int unsigned n_eng,
                                                input int unsigned pidx, input int unsigned midx);
        if (u < n_eng)       return u;
        else if (u == n_eng) return pidx;
        else                 return midx;
    endfunction

endpackage

// File: rtl/mirq_addr.sv
module mirq_addr #(
    parameter int unsigned NUM_ENG   = 4,
    parameter int unsigned ADDR_W    = 11,
    parameter int unsigned UNIT_W    = 3,
    parameter int unsigned SRC_BASE  = 'h400,
    parameter int unsigned STAT_BASE = 0,
    parameter int unsigned PCTL_IDX  = 25,
    parameter int unsigned MCTL_IDX  = 26,
    parameter int unsigned ENG_BIT   = 0,
    parameter int unsigned CTL_BIT   = 0
) (
    input  logic [UNIT_W-1:0] unit,
    input  logic              stat_phase,
    output logic [ADDR_W-1:0] addr
);
    import mirq_pkg::*;

    int unsigned idx;
    int unsigned bsel;

    always_comb begin
        idx  = unit_to_idx(int'(unit), NUM_ENG, PCTL_IDX, MCTL_IDX);
        bsel = (int'(unit) < NUM_ENG) ? ENG_BIT : CTL_BIT;
        if (stat_phase)
            addr = ADDR_W'(STAT_BASE + idx * SLOT_BYTES + bsel);
        else
            addr = ADDR_W'(SRC_BASE + idx);
    end

endmodule

// File: rtl/mirq_disp.sv
module mirq_disp #(
    parameter int unsigned NUM_ENG = 4,
    parameter int unsigned UNIT_W  = 3
) (
    input  logic               fire,
    input  logic [UNIT_W-1:0]  unit,
    output logic [NUM_ENG-1:0] eng_disp,
    output logic               pctl_disp,
    output logic               mctl_disp
);
    for (genvar g = 0; g < NUM_ENG; g++) begin : g_eng
        assign eng_disp[g] = fire && (unit == UNIT_W'(g));
    end

    assign pctl_disp = fire && (unit == UNIT_W'(NUM_ENG));
    assign mctl_disp = fire && (unit == UNIT_W'(NUM_ENG + 1));

endmodule

// File: rtl/mirq_scan.sv
module mirq_scan #(
    parameter int unsigned NUM_ENG   = 4,
    parameter int unsigned ADDR_W    = 11,
    parameter int unsigned SRC_BASE  = 'h400,
    parameter int unsigned STAT_BASE = 0,
    parameter int unsigned PCTL_IDX  = 25,
    parameter int unsigned MCTL_IDX  = 26,
    parameter int unsigned ENG_BIT   = 0,
    parameter int unsigned CTL_BIT   = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               irq,
    input  logic               region_ok,
    input  logic               has_media,
    output logic               mem_req,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [7:0]         mem_wdata,
    input  logic [7:0]         mem_rdata,
    input  logic               mem_gnt,
    output logic [NUM_ENG-1:0] eng_disp,
    output logic               pctl_disp,
    output logic               mctl_disp,
    output logic               err_vld,
    output logic [ADDR_W-1:0]  err_addr,
    output logic [7:0]         err_val
);
    import mirq_pkg::*;

    localparam int unsigned UNITS  = NUM_ENG + 2;
    localparam int unsigned UNIT_W = $clog2(UNITS);

    scan_st_e          st;
    logic [UNIT_W-1:0] unit;
    logic              stat_phase;
    logic              pend;
    logic [UNIT_W-1:0] last_unit;
    logic              fire;

    assign last_unit = has_media ? UNIT_W'(NUM_ENG + 1) : UNIT_W'(NUM_ENG);
    assign mem_req   = (st == ST_RD) || (st == ST_CLR);
    assign mem_we    = (st == ST_CLR);
    assign mem_wdata = 8'h00;
    assign fire      = (st == ST_DISP);

    mirq_addr #(
        .NUM_ENG(NUM_ENG), .ADDR_W(ADDR_W), .UNIT_W(UNIT_W),
        .SRC_BASE(SRC_BASE), .STAT_BASE(STAT_BASE),
        .PCTL_IDX(PCTL_IDX), .MCTL_IDX(MCTL_IDX),
        .ENG_BIT(ENG_BIT), .CTL_BIT(CTL_BIT)
    ) u_addr (
        .unit       (unit),
        .stat_phase (stat_phase),
        .addr       (mem_addr)
    );

    mirq_disp #(.NUM_ENG(NUM_ENG), .UNIT_W(UNIT_W)) u_disp (
        .fire      (fire),
        .unit      (unit),
        .eng_disp  (eng_disp),
        .pctl_disp (pctl_disp),
        .mctl_disp (mctl_disp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            unit       <= '0;
            stat_phase <= 1'b0;
            pend       <= 1'b0;
            err_vld    <= 1'b0;
            err_addr   <= '0;
            err_val    <= 8'h00;
        end else begin
            err_vld <= 1'b0;
            if (irq && st != ST_IDLE) pend <= 1'b1;
            case (st)
                ST_IDLE: begin
                    if (irq || pend) begin
                        pend <= 1'b0;
                        if (region_ok) begin
                            st         <= ST_RD;
                            unit       <= '0;
                            stat_phase <= 1'b0;
                        end
                    end
                end
                ST_RD: if (mem_gnt) st <= ST_WT;
                ST_WT: begin
                    if (mem_rdata != 8'h00) begin
                        st <= ST_CLR;
                        if (mem_rdata != MARK_OK) begin
                            err_vld  <= 1'b1;
                            err_addr <= mem_addr;
                            err_val  <= mem_rdata;
                        end
                    end else begin
                        st <= ST_NEXT;
                    end
                end
                ST_CLR: begin
                    if (mem_gnt) begin
                        if (!stat_phase) begin
                            stat_phase <= 1'b1;
                            st         <= ST_RD;
                        end else begin
                            st <= ST_DISP;
                        end
                    end
                end
                ST_DISP: st <= ST_NEXT;
                ST_NEXT: begin
                    stat_phase <= 1'b0;
                    if (unit >= last_unit) begin
                        st <= ST_IDLE;
                    end else begin
                        unit <= unit + 1'b1;
                        st   <= ST_RD;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R2: never two targets at once
    a_r2_one_target: assert property (@(posedge clk) disable iff (rst)
        $onehot0({eng_disp, pctl_disp, mctl_disp}));

    // R8: a pulse follows an accepted clearing write
    a_r8_disp_after_write: assert property (@(posedge clk) disable iff (rst)
        (|{eng_disp, pctl_disp, mctl_disp}) |-> $past(mem_req && mem_we && mem_gnt));

    // R8: pulses are one cycle wide
    a_r8_pulse_width: assert property (@(posedge clk) disable iff (rst)
        (|{eng_disp, pctl_disp, mctl_disp}) |=> !(|{eng_disp, pctl_disp, mctl_disp}));

    // R6: media target only when present
    a_r6_media_gated: assert property (@(posedge clk) disable iff (rst)
        mctl_disp |-> has_media);

    // R5: reported values are malformed markers
    a_r5_err_value: assert property (@(posedge clk) disable iff (rst)
        err_vld |-> (err_val != 8'h00 && err_val != MARK_OK));

    // R7: an interrupt in an invalid region starts nothing
    a_r7_region_gate: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && irq && !region_ok) |=> !mem_req);

endmodule

// File: tb/test_mirq_scan.sv
module test_mirq_scan;

    localparam int AW = 11;
    localparam int NE = 4;

    // {has_media, src_mask[5:0], stat_mask[5:0]}; units 0..3 engines, 4 primary, 5 media
    localparam logic [12:0] VEC [6] = '{
        {1'b1, 6'b111111, 6'b111111},
        {1'b0, 6'b111111, 6'b111111},
        {1'b1, 6'b010101, 6'b010101},
        {1'b1, 6'b101010, 6'b001010},
        {1'b0, 6'b100000, 6'b100000},
        {1'b1, 6'b000000, 6'b111111}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic irq = 1'b0;
    logic region_ok = 1'b1;
    logic has_media = 1'b1;
    logic mem_req, mem_we, mem_gnt;
    logic [AW-1:0] mem_addr, err_addr;
    logic [7:0] mem_wdata, mem_rdata, err_val;
    logic [NE-1:0] eng_disp;
    logic pctl_disp, mctl_disp, err_vld;

    logic [7:0] mem [2048];
    logic       tb_we = 1'b0;
    logic [AW-1:0] tb_addr = '0;
    logic [7:0] tb_data = 8'h00;
    int  gnt_mode = 0;
    int  cyc = 0;

    int checks = 0, errors = 0;
    int nseq = 0, seq_code = 0, acc = 0, r8_bad = 0, nerr = 0;
    logic prev_wr = 1'b0;
    logic [AW-1:0] e_addr [4];
    logic [7:0]    e_val  [4];

    always #5 clk = ~clk;

    mirq_scan i_mirq_scan (
        .clk(clk), .rst(rst), .irq(irq), .region_ok(region_ok), .has_media(has_media),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_gnt(mem_gnt), .eng_disp(eng_disp),
        .pctl_disp(pctl_disp), .mctl_disp(mctl_disp),
        .err_vld(err_vld), .err_addr(err_addr), .err_val(err_val)
    );

    always @(posedge clk) begin
        if (mem_req && mem_gnt) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        mem_rdata     <= mem[mem_addr];
        end
        if (tb_we) mem[tb_addr] <= tb_data;
    end

    initial mem_gnt = 1'b1;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1 mem_gnt = (gnt_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
    end

    // monitor: dispatch order, errors, accesses, pulse timing
    always @(negedge clk) begin
        if (!rst) begin
            if (|{eng_disp, pctl_disp, mctl_disp}) begin
                int id;
                id = 0;
                for (int k = 0; k < NE; k++) if (eng_disp[k]) id = k;
                if (pctl_disp) id = NE;
                if (mctl_disp) id = NE + 1;
                seq_code = seq_code * 8 + id + 1;
                nseq++;
                if (!prev_wr) r8_bad++;
            end
            if (err_vld && nerr < 4) begin
                e_addr[nerr] = err_addr;
                e_val[nerr]  = err_val;
                nerr++;
            end
            if (mem_req && mem_gnt) acc++;
        end
        prev_wr = mem_req && mem_we && mem_gnt;
    end

    initial begin
        #300000;
        checks++; errors++;
        $display("FAIL watchdog: run did not finish (act 0 exp 1)");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    function automatic int uidx(int u);
        return (u < NE) ? u : (u == NE) ? 25 : 26;
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: act %0h exp %0h", req, what, act, exp);
        end
    endtask

    task automatic poke(input int a, input logic [7:0] d);
        @(negedge clk);
        tb_we = 1'b1; tb_addr = AW'(a); tb_data = d;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic pulse_irq();
        @(negedge clk);
        irq = 1'b1;
        @(negedge clk);
        irq = 1'b0;
    endtask

    task automatic clear_mon();
        nseq = 0; seq_code = 0; acc = 0; r8_bad = 0; nerr = 0;
    endtask

    task automatic setup(input logic [5:0] src, input logic [5:0] st);
        for (int u = 0; u < 6; u++) begin
            poke('h400 + uidx(u), src[u] ? 8'hFF : 8'h00);
            poke(uidx(u) * 16, st[u] ? 8'hFF : 8'h00);
            poke(uidx(u) * 16 + 3, 8'hFF);
        end
    endtask

    task automatic run_vec(input logic [12:0] v, input string tag);
        logic hm; logic [5:0] src, st;
        int exp_code, exp_n;
        logic [5:0] a_src, e_src, a_st, e_st;
        logic sent_ok;
        hm = v[12]; src = v[11:6]; st = v[5:0];
        setup(src, st);
        has_media = hm;
        clear_mon();
        pulse_irq();
        repeat (300) @(negedge clk);
        exp_code = 0; exp_n = 0; sent_ok = 1'b1;
        for (int u = 0; u < 6; u++) begin
            bit rcv;
            rcv = src[u] && (u < 5 || hm);
            if (rcv && st[u]) begin exp_code = exp_code * 8 + u + 1; exp_n++; end
            e_src[u] = rcv ? 1'b0 : src[u];
            e_st[u]  = rcv ? 1'b0 : st[u];
            a_src[u] = (mem['h400 + uidx(u)] != 8'h00);
            a_st[u]  = (mem[uidx(u) * 16] != 8'h00);
            if (mem[uidx(u) * 16 + 3] != 8'hFF) sent_ok = 1'b0;
        end
        chk(seq_code == exp_code && nseq == exp_n, "R2", {tag, " dispatch order"}, seq_code, exp_code);
        chk(a_src == e_src, "R3", {tag, " source bytes cleared"}, a_src, e_src);
        chk(a_st == e_st, "R4", {tag, " status bytes"}, a_st, e_st);
        chk(sent_ok, "R10", {tag, " neighbour byte kept"}, sent_ok, 1);
        if (!hm && src[5])
            chk(a_src[5], "R6", {tag, " media source untouched"}, a_src[5], 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!mem_req, "R1", "no request after reset", mem_req, 0);
        chk({eng_disp, pctl_disp, mctl_disp} == '0, "R1", "dispatch low after reset",
            {eng_disp, pctl_disp, mctl_disp}, 0);
        chk(!err_vld, "R1", "error low after reset", err_vld, 0);

        for (int i = 0; i < 6; i++) begin
            string tag;
            tag = $sformatf("vec%0d", i);
            run_vec(VEC[i], tag);
        end

        // R5 malformed markers in source and status tables
        setup(6'b010100, 6'b010100);
        poke('h400 + 2, 8'h5A);
        poke(25 * 16, 8'h11);
        has_media = 1'b1;
        clear_mon();
        pulse_irq();
        repeat (200) @(negedge clk);
        chk(nerr == 2, "R5", "two error reports", nerr, 2);
        chk(e_addr[0] == AW'('h402) && e_val[0] == 8'h5A, "R5", "source error addr/val",
            {e_addr[0], e_val[0]}, {11'h402, 8'h5A});
        chk(e_addr[1] == AW'(25 * 16) && e_val[1] == 8'h11, "R5", "status error addr/val",
            {e_addr[1], e_val[1]}, {11'h190, 8'h11});
        chk(seq_code == 8 * 3 + 5, "R5", "malformed still dispatched", seq_code, 8 * 3 + 5);
        chk(mem['h402] == 8'h00 && mem[25 * 16] == 8'h00, "R5", "malformed bytes cleared",
            {mem['h402], mem[25 * 16]}, 0);

        // R7 invalid region
        setup(6'b000001, 6'b000001);
        region_ok = 1'b0;
        clear_mon();
        pulse_irq();
        repeat (40) @(negedge clk);
        chk(acc == 0, "R7", "no access with region invalid", acc, 0);
        chk(mem['h400] == 8'hFF && nseq == 0, "R7", "marker left in place", mem['h400], 8'hFF);
        region_ok = 1'b1;
        repeat (40) @(negedge clk);
        chk(acc == 0, "R7", "ignored interrupt not kept", acc, 0);

        // R8 stalling grant
        gnt_mode = 1;
        run_vec(13'b1_111111_111111, "stall");
        chk(r8_bad == 0, "R8", "pulse right after accepted write", r8_bad, 0);
        gnt_mode = 0;

        // R9 rescan after interrupt mid-scan
        setup(6'b000001, 6'b000001);
        has_media = 1'b1;
        clear_mon();
        pulse_irq();
        repeat (10) @(negedge clk);
        poke('h400, 8'hFF);
        poke(0, 8'hFF);
        pulse_irq();
        pulse_irq();
        repeat (200) @(negedge clk);
        chk(seq_code == 8 + 1 && nseq == 2, "R9", "single rescan picks up new mark", seq_code, 9);
        chk(mem['h400] == 8'h00, "R9", "rescan cleared marker", mem['h400], 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule